// File: doc/BRIEF.md
# Multi-hart halt/resume controller

This block holds the run-control state for a small group of harts inside a debug controller. A debugger writes a control word that carries a hart index, a use-mask flag and two action bits (halt and resume). A separate write loads a hart array mask. The written fields decide which harts an action applies to. The block keeps a halt-request level and a resume-acknowledge bit for each hart. It drives one halt-request line and one resume pulse line to each hart.

Each hart reports halted, running and unavailable status. The block sorts every hart into exactly one status class. It then reduces each class, and the resume-acknowledge bits, into an "any" flag and an "all" flag over the currently selected set. An index at or above the number of implemented harts counts as a nonexistent hart. The stored index keeps only its implemented bits, so a debugger can find the index width by writing all ones and reading the value back.

Top module: `hart_runctl`

## Requirements
- R1: After reset, every halt-request line and resume line is 0, the read-back index, use-mask flag and mask are all 0, and each resume-acknowledge bit holds the value of parameter ACK_RST_VAL. With the default ACK_RST_VAL=1, any_resumeack reads 1 two clocks after reset is released, because hart 0 is selected.
- R2: A control write with the halt bit at 1 sets the halt-request line of every hart selected by that write, starting the cycle after the write. A control write with the halt bit at 0 clears the halt-request line of the selected harts only. The line holds its level between writes, and harts that are not selected keep their lines.
- R3: A control write with the resume bit at 1 and the halt bit at 0 clears the resume-acknowledge bit of every selected hart. In the cycle after the write it raises a resume pulse, exactly one cycle long, to each selected hart whose status class is halted.
- R4: A hart's resume-acknowledge bit sets again on the first clock edge after the write at which its status class is running.
- R5: A selected hart whose status class is running gets no resume pulse. A write with both the halt bit and the resume bit at 1 sends no resume pulse.
- R6: With the use-mask flag at 1, bit n of the mask selects hart n. With the flag at 0, only the hart named by the index is selected. Setting or clearing the flag does not change the mask read-back.
- R7: The index keeps only its low SEL_W bits. Writing all ones reads back as 2**SEL_W-1, zero-extended to IDX_IN_W bits.
- R8: Status classes, in priority order: the hart is unavailable if its unavailable input is 1, or if neither its halted nor its running input is 1; otherwise it is halted if its halted input is 1; otherwise it is running. For each class, the "any" flag is 1 when at least one selected hart is in that class. The "all" flag is 1 when every selected hart is in that class. The flags reflect the selection and status one clock after the stored selection changes.
- R9: With the use-mask flag at 0, an index at or above NUM_HARTS selects a nonexistent hart. Both any_nonexist and all_nonexist then read 1, and every other flag reads 0.
- R10: When no hart is selected (use-mask flag at 1 and mask at 0), every "any" flag and every "all" flag reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_idx | input | IDX_IN_W | Hart index field |
| ctl_usemask | input | 1 | Use-mask flag field |
| ctl_halt | input | 1 | Halt-request field |
| ctl_resume | input | 1 | Resume-request field |
| mask_we | input | 1 | Hart array mask write strobe |
| mask_wdata | input | NUM_HARTS | Mask write value |
| idx_rd | output | IDX_IN_W | Stored index, zero-extended |
| usemask_rd | output | 1 | Stored use-mask flag |
| mask_rd | output | NUM_HARTS | Stored mask |
| hart_halted | input | NUM_HARTS | Per-hart halted status |
| hart_running | input | NUM_HARTS | Per-hart running status |
| hart_unavail | input | NUM_HARTS | Per-hart unavailable status |
| halt_req | output | NUM_HARTS | Per-hart halt-request level |
| resume_req | output | NUM_HARTS | Per-hart single-cycle resume pulse |
| any_halted | output | 1 | Some selected hart is halted |
| all_halted | output | 1 | Every selected hart is halted |
| any_running | output | 1 | Some selected hart is running |
| all_running | output | 1 | Every selected hart is running |
| any_unavail | output | 1 | Some selected hart is unavailable |
| all_unavail | output | 1 | Every selected hart is unavailable |
| any_nonexist | output | 1 | A nonexistent hart is selected |
| all_nonexist | output | 1 | Every selected hart is nonexistent |
| any_resumeack | output | 1 | Some selected hart has its resume-ack bit set |
| all_resumeack | output | 1 | Every selected hart has its resume-ack bit set |

## Verification
The summary reduction is swept over every combination of the four ways a hart can present status: running, halted, unavailable by input, and reporting neither. This is done for each of the three harts and for every mask value and every index, including the nonexistent one. The sweep tells apart the "any" and "all" reductions, the class priority and the empty selection. Directed sequences then cover the halt level, set and cleared on different selections, and a resume over a mixed halted/running mask. That resume shows which harts receive a pulse, that the pulse lasts one cycle, and when each acknowledge returns. A combined halt-and-resume write, the all-ones index read-back and mask retention across use-mask toggles are checked as well.

// File: rtl/hrc_pkg.sv
package hrc_pkg;
  typedef struct packed {
    logic any_h;
    logic all_h;
    logic any_r;
    logic all_r;
    logic any_u;
    logic all_u;
    logic any_n;
    logic all_n;
    logic any_a;
    logic all_a;
  } hrc_flags_t;
endpackage

// File: rtl/hrc_select.sv
module hrc_select #(
  parameter int NUM_HARTS = 3,
  parameter int SEL_W     = 2
) (
  input  logic [SEL_W-1:0]     idx,
  input  logic                 usemask,
  input  logic [NUM_HARTS-1:0] mask,
  output logic [NUM_HARTS-1:0] sel,
  output logic                 nonex
);
  always_comb begin
    sel   = '0;
    nonex = 1'b0;
    if (usemask) begin
      sel = mask;
    end else if (int'(idx) >= NUM_HARTS) begin
      nonex = 1'b1;
    end else begin
      for (int i = 0; i < NUM_HARTS; i++) begin
        sel[i] = (int'(idx) == i);
      end
    end
  end
endmodule

// File: rtl/hrc_hart_slot.sv
module hrc_hart_slot #(
  parameter bit ACK_RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_act,
  input  logic wr_sel,
  input  logic wr_halt,
  input  logic wr_resume,
  input  logic st_halted,
  input  logic st_running,
  input  logic st_unavail,
  output logic cls_h,
  output logic cls_r,
  output logic cls_u,
  output logic hreq_q,
  output logic rpulse_q,
  output logic ack_q
);
  logic hit;
  logic do_resume;

  assign cls_u     = st_unavail | ~(st_halted | st_running);
  assign cls_h     = ~cls_u & st_halted;
  assign cls_r     = ~cls_u & ~st_halted & st_running;
  assign hit       = wr_act & wr_sel;
  assign do_resume = hit & wr_resume & ~wr_halt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hreq_q   <= 1'b0;
      rpulse_q <= 1'b0;
      ack_q    <= ACK_RST_VAL;
    end else begin
      if (hit) hreq_q <= wr_halt;
      rpulse_q <= do_resume & cls_h;
      if (do_resume)  ack_q <= 1'b0;
      else if (cls_r) ack_q <= 1'b1;
    end
  end

  // R2: halt write on a selected hart raises the level next cycle
  a_r2_halt_set: assert property (@(posedge clk) disable iff (rst)
    (hit && wr_halt) |=> hreq_q);
  // R2: unselected harts keep their level
  a_r2_halt_hold: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(hreq_q));
  // R5: a running hart never gets a pulse
  a_r5_no_pulse_running: assert property (@(posedge clk) disable iff (rst)
    cls_r |=> !rpulse_q);
  // R3: accepted resume leaves ack low
  a_r3_ack_low: assert property (@(posedge clk) disable iff (rst)
    do_resume |=> !ack_q);
  // R8: classes are exclusive and cover every case
  a_r8_one_class: assert property (@(posedge clk) disable iff (rst)
    $countones({cls_h, cls_r, cls_u}) == 1);
endmodule

// File: rtl/hrc_summary.sv
module hrc_summary
  import hrc_pkg::*;
#(
  parameter int NUM_HARTS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_HARTS-1:0] sel,
  input  logic                 nonex,
  input  logic [NUM_HARTS-1:0] cls_h,
  input  logic [NUM_HARTS-1:0] cls_r,
  input  logic [NUM_HARTS-1:0] cls_u,
  input  logic [NUM_HARTS-1:0] ack,
  output hrc_flags_t           flags_q
);
  hrc_flags_t flags_d;
  logic       some;

  always_comb begin
    some          = |sel;
    flags_d.any_h = |(sel & cls_h);
    flags_d.all_h = some & (&(cls_h | ~sel));
    flags_d.any_r = |(sel & cls_r);
    flags_d.all_r = some & (&(cls_r | ~sel));
    flags_d.any_u = |(sel & cls_u);
    flags_d.all_u = some & (&(cls_u | ~sel));
    flags_d.any_n = nonex;
    flags_d.all_n = nonex;
    flags_d.any_a = |(sel & ack);
    flags_d.all_a = some & (&(ack | ~sel));
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

  // R8: an "all" flag implies its "any" flag
  a_r8_all_any: assert property (@(posedge clk) disable iff (rst)
    (!flags_q.all_h || flags_q.any_h) && (!flags_q.all_r || flags_q.any_r) &&
    (!flags_q.all_u || flags_q.any_u) && (!flags_q.all_a || flags_q.any_a));
  // R8: at most one "all" class flag at a time
  a_r8_all_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flags_q.all_h, flags_q.all_r, flags_q.all_u, flags_q.all_n}));
  // R10: empty selection gives no flags
  a_r10_empty: assert property (@(posedge clk) disable iff (rst)
    (sel == '0 && !nonex) |=> (flags_q == '0));
endmodule

// File: rtl/hart_runctl.sv
module hart_runctl
  import hrc_pkg::*;
#(
  parameter int NUM_HARTS   = 3,
  parameter int SEL_W       = 2,
  parameter int IDX_IN_W    = 20,
  parameter bit ACK_RST_VAL = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_we,
  input  logic [IDX_IN_W-1:0]  ctl_idx,
  input  logic                 ctl_usemask,
  input  logic                 ctl_halt,
  input  logic                 ctl_resume,
  input  logic                 mask_we,
  input  logic [NUM_HARTS-1:0] mask_wdata,
  output logic [IDX_IN_W-1:0]  idx_rd,
  output logic                 usemask_rd,
  output logic [NUM_HARTS-1:0] mask_rd,
  input  logic [NUM_HARTS-1:0] hart_halted,
  input  logic [NUM_HARTS-1:0] hart_running,
  input  logic [NUM_HARTS-1:0] hart_unavail,
  output logic [NUM_HARTS-1:0] halt_req,
  output logic [NUM_HARTS-1:0] resume_req,
  output logic                 any_halted,
  output logic                 all_halted,
  output logic                 any_running,
  output logic                 all_running,
  output logic                 any_unavail,
  output logic                 all_unavail,
  output logic                 any_nonexist,
  output logic                 all_nonexist,
  output logic                 any_resumeack,
  output logic                 all_resumeack
);
  localparam int PAD_W = IDX_IN_W - SEL_W;

  logic [SEL_W-1:0]     idx_q;
  logic                 usemask_q;
  logic [NUM_HARTS-1:0] mask_q;
  logic [NUM_HARTS-1:0] wr_sel, cur_sel;
  logic                 wr_nonex, cur_nonex;
  logic [NUM_HARTS-1:0] cls_h, cls_r, cls_u, ack;
  hrc_flags_t           flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      usemask_q <= 1'b0;
      mask_q    <= '0;
    end else begin
      if (ctl_we) begin
        idx_q     <= ctl_idx[SEL_W-1:0];
        usemask_q <= ctl_usemask;
      end
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign idx_rd     = {{PAD_W{1'b0}}, idx_q};
  assign usemask_rd = usemask_q;
  assign mask_rd    = mask_q;

  hrc_select #(.NUM_HARTS(NUM_HARTS), .SEL_W(SEL_W)) u_wsel (
    .idx(ctl_idx[SEL_W-1:0]), .usemask(ctl_usemask), .mask(mask_q),
    .sel(wr_sel), .nonex(wr_nonex));

  hrc_select #(.NUM_HARTS(NUM_HARTS), .SEL_W(SEL_W)) u_csel (
    .idx(idx_q), .usemask(usemask_q), .mask(mask_q),
    .sel(cur_sel), .nonex(cur_nonex));

  for (genvar g = 0; g < NUM_HARTS; g++) begin : g_slot
    hrc_hart_slot #(.ACK_RST_VAL(ACK_RST_VAL)) u_slot (
      .clk(clk), .rst(rst),
      .wr_act(ctl_we), .wr_sel(wr_sel[g]),
      .wr_halt(ctl_halt), .wr_resume(ctl_resume),
      .st_halted(hart_halted[g]), .st_running(hart_running[g]),
      .st_unavail(hart_unavail[g]),
      .cls_h(cls_h[g]), .cls_r(cls_r[g]), .cls_u(cls_u[g]),
      .hreq_q(halt_req[g]), .rpulse_q(resume_req[g]), .ack_q(ack[g]));
  end

  hrc_summary #(.NUM_HARTS(NUM_HARTS)) u_sum (
    .clk(clk), .rst(rst), .sel(cur_sel), .nonex(cur_nonex),
    .cls_h(cls_h), .cls_r(cls_r), .cls_u(cls_u), .ack(ack),
    .flags_q(flags));

  assign any_halted    = flags.any_h;
  assign all_halted    = flags.all_h;
  assign any_running   = flags.any_r;
  assign all_running   = flags.all_r;
  assign any_unavail   = flags.any_u;
  assign all_unavail   = flags.all_u;
  assign any_nonexist  = flags.any_n;
  assign all_nonexist  = flags.all_n;
  assign any_resumeack = flags.any_a;
  assign all_resumeack = flags.all_a;

  // R9: a selected nonexistent hart suppresses every other class flag
  a_r9_nonex_alone: assert property (@(posedge clk) disable iff (rst)
    any_nonexist |-> !(any_halted || any_running || any_unavail || any_resumeack));
  // R6: toggling the use-mask flag alone leaves the mask unchanged
  a_r6_mask_kept: assert property (@(posedge clk) disable iff (rst)
    !mask_we |=> $stable(mask_rd));
  // R5: no pulse after a combined halt and resume write
  a_r5_combined: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_halt) |=> (resume_req == '0));
endmodule

// File: tb/hart_runctl_tb_top.sv
module hart_runctl_tb_top;
  localparam int NH = 3;
  localparam int SW = 2;
  localparam int IW = 20;

  logic clk = 0, rst = 1;
  logic ctl_we = 0, ctl_usemask = 0, ctl_halt = 0, ctl_resume = 0;
  logic [IW-1:0] ctl_idx = '0;
  logic mask_we = 0;
  logic [NH-1:0] mask_wdata = '0;
  logic [IW-1:0] idx_rd;
  logic usemask_rd;
  logic [NH-1:0] mask_rd, hh = '0, hr = '0, hu = '0, halt_req, resume_req;
  logic any_h, all_h, any_r, all_r, any_u, all_u, any_n, all_n, any_a, all_a;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hart_runctl #(.NUM_HARTS(NH), .SEL_W(SW), .IDX_IN_W(IW), .ACK_RST_VAL(1'b1)) dut_i (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_idx(ctl_idx),
    .ctl_usemask(ctl_usemask), .ctl_halt(ctl_halt), .ctl_resume(ctl_resume),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .idx_rd(idx_rd),
    .usemask_rd(usemask_rd), .mask_rd(mask_rd), .hart_halted(hh),
    .hart_running(hr), .hart_unavail(hu), .halt_req(halt_req),
    .resume_req(resume_req), .any_halted(any_h), .all_halted(all_h),
    .any_running(any_r), .all_running(all_r), .any_unavail(any_u),
    .all_unavail(all_u), .any_nonexist(any_n), .all_nonexist(all_n),
    .any_resumeack(any_a), .all_resumeack(all_a));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input int idx, input bit um, input bit h, input bit r);
    @(negedge clk);
    ctl_we = 1; ctl_idx = IW'(idx); ctl_usemask = um; ctl_halt = h; ctl_resume = r;
    @(negedge clk);
    ctl_we = 0; ctl_halt = 0; ctl_resume = 0;
  endtask

  task automatic wr_mask(input logic [NH-1:0] m);
    @(negedge clk);
    mask_we = 1; mask_wdata = m;
    @(negedge clk);
    mask_we = 0;
  endtask

  // expected class flags {anyH,allH,anyR,allR,anyU,allU,anyN,allN}
  function automatic logic [7:0] expect_flags(input logic [NH-1:0] sel, input bit nx,
      input logic [NH-1:0] h, input logic [NH-1:0] r, input logic [NH-1:0] u);
    int nsel = 0, nh = 0, nr = 0, nu = 0;
    logic [7:0] e;
    for (int i = 0; i < NH; i++) begin
      if (sel[i]) begin
        nsel++;
        if (u[i] || !(h[i] || r[i])) nu++;
        else if (h[i]) nh++;
        else nr++;
      end
    end
    e[7] = nh > 0;  e[6] = nsel > 0 && nh == nsel;
    e[5] = nr > 0;  e[4] = nsel > 0 && nr == nsel;
    e[3] = nu > 0;  e[2] = nsel > 0 && nu == nsel;
    e[1] = nx;      e[0] = nx;
    return e;
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 halt_req", 32'(halt_req), 0);
    chk("R1 resume_req", 32'(resume_req), 0);
    chk("R1 idx_rd", idx_rd, 0);
    chk("R1 mask_rd", 32'({usemask_rd, mask_rd}), 0);
    chk("R1 any_resumeack", 32'(any_a), 1);

    // R7 index width
    wr_ctl(IW'('1), 0, 0, 0);
    chk("R7 idx readback", idx_rd, (1 << SW) - 1);

    // R6 mask retention across use-mask toggles
    wr_mask(3'b101);
    wr_ctl(0, 1, 0, 0);
    chk("R6 mask after set", 32'(mask_rd), 3'b101);
    wr_ctl(0, 0, 0, 0);
    chk("R6 mask after clear", 32'(mask_rd), 3'b101);
    chk("R6 usemask rd", 32'(usemask_rd), 0);

    // R8 R9 R10 R6 sweep
    for (int c = 0; c < 64; c++) begin
      for (int s = 0; s < 12; s++) begin
        logic [NH-1:0] sel;
        bit nx;
        for (int i = 0; i < NH; i++) begin
          int k = (c >> (2 * i)) & 3;
          hh[i] = (k == 1); hr[i] = (k == 0) || (k == 2); hu[i] = (k == 2);
        end
        if (s < 8) begin
          wr_mask(NH'(s));
          wr_ctl(0, 1, 0, 0);
          sel = NH'(s); nx = 0;
        end else begin
          wr_ctl(s - 8, 0, 0, 0);
          nx = (s - 8) >= NH;
          sel = nx ? '0 : NH'(1 << (s - 8));
        end
        @(negedge clk);
        if (s == 0)
          chk("R10 empty selection", 32'({any_h, all_h, any_r, all_r, any_u, all_u, any_n, all_n, any_a, all_a}), 0);
        else if (nx)
          chk("R9 nonexistent", 32'({any_h, all_h, any_r, all_r, any_u, all_u, any_n, all_n, any_a, all_a}), 32'b0000001100);
        else
          chk("R8 sweep", 32'({any_h, all_h, any_r, all_r, any_u, all_u, any_n, all_n}),
              32'(expect_flags(sel, nx, hh, hr, hu)));
      end
    end

    // R2 halt level
    hh = '0; hr = '1; hu = '0;
    wr_mask(3'b101);
    wr_ctl(0, 1, 1, 0);
    chk("R2 halt set", 32'(halt_req), 3'b101);
    wr_ctl(1, 0, 0, 0);
    chk("R2 unselected kept", 32'(halt_req), 3'b101);
    repeat (3) @(negedge clk);
    chk("R2 level held", 32'(halt_req), 3'b101);
    wr_ctl(0, 1, 0, 0);
    chk("R2 halt cleared", 32'(halt_req), 0);

    // R3 R4 R5 resume on mixed set
    hh = 3'b101; hr = 3'b010;
    wr_mask(3'b111);
    wr_ctl(0, 1, 0, 1);
    chk("R3 pulse to halted only", 32'(resume_req), 3'b101);
    @(negedge clk);
    chk("R3 pulse single cycle", 32'(resume_req), 0);
    chk("R3 ack cleared", 32'(any_a), 0);
    @(negedge clk);
    chk("R4 running ack back", 32'({any_a, all_a}), 2'b10);
    hh = 3'b000; hr = 3'b111;
    @(negedge clk);
    @(negedge clk);
    chk("R4 all acks back", 32'({any_a, all_a}), 2'b11);

    // R5 resume to running hart, and combined halt plus resume
    wr_ctl(1, 0, 0, 1);
    chk("R5 running ignores resume", 32'(resume_req), 0);
    hh = 3'b111; hr = 3'b000;
    wr_ctl(0, 1, 1, 1);
    chk("R5 combined no pulse", 32'(resume_req), 0);
    chk("R5 combined halt set", 32'(halt_req), 3'b111);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule